// File: doc/BRIEF.md
# Programmable Delay Trigger Generator

This block turns a single start event into a schedule of timed pulses for an analog-to-digital converter. A start event is either a rising edge on an external trigger pin or a write to a software strobe address. Which of the two counts is set by a control bit. A start clears an internal counter and sets it running. Each of several channels compares the count with its own delay value and emits a one-clock pulse on a match. A channel can also be set to bypass its delay. It then pulses straight after the start. A single trigger output is high whenever any channel pulse is high.

The counter can run in one-shot mode, where it counts up to a modulus and stops. It can also run in continuous mode, where it wraps to zero after the modulus, so one start gives a repeating stream of pulses. A halt input freezes the counter for on-chip debugging. Configuration goes through a simple write-only register port.

Top module: `pdly_trig`

## Requirements
- R1: While the enable bit (control bit 0) is 0, the counter is stopped, every pulse output and the trigger output are low, and start events are ignored.
- R2: With the software-select bit (control bit 2) at 0, a low-to-high change on `ext_trig` starts the schedule. The input passes through two synchronizing flops and an edge detector, so a bypassed channel pulses in the third clock after the pin rises. Writes to the strobe address have no effect in this setting.
- R3: With the software-select bit at 1, a write to address 1 with data bit 0 set starts the schedule, and a bypassed channel pulses in the clock right after that write. Edges on `ext_trig` have no effect in this setting.
- R4: A channel that is enabled and not bypassed, with delay D, emits a single-clock pulse D+1 clocks after the clock in which a bypassed channel pulses for the same start.
- R5: In one-shot mode (control bit 1 at 0), the counter stops once it reaches the modulus (address 2). Each delayed channel pulses at most once per start, and a channel whose delay exceeds the modulus never pulses.
- R6: In continuous mode (control bit 1 at 1), the counter returns to zero after reaching the modulus and keeps counting, so each delayed channel pulses every modulus+1 clocks.
- R7: A channel whose bit is set in the bypass mask (address 4) pulses for one clock right after each start event, whatever its delay, in either mode.
- R8: Only channels set in the channel-enable mask (address 3) ever pulse, and `trig` is high exactly when some bit of `pretrig` is high.
- R9: While `dbg_halt` is high, the counter holds its value and no delayed pulse is emitted. After release, counting resumes from the held value, so pending pulses shift later by the length of the halt.
- R10: A start event while the counter is running restarts the count at zero and reschedules every channel from that event.
- R11: The delay of channel i is written at address 8+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | DW | Configuration write data |
| ext_trig | input | 1 | Asynchronous external start input |
| dbg_halt | input | 1 | Debug halt, freezes the counter |
| pretrig | output | CH | Per-channel pulse outputs |
| trig | output | 1 | OR of all channel pulses |

## Verification
The schedule is swept over every modulus from 0 to 4, in both modes, with several bypass and enable masks. The delays are chosen so that some fall on the modulus, some fall inside it and some lie past it. This separates wrap-around behaviour from stop-at-modulus behaviour, and shows that delays past the modulus stay silent. Starts from both sources are tried with the other source active, which shows that the source select really blocks the unselected path. Separate runs with a mid-schedule halt and a mid-schedule restart check that a halt shifts pending pulses later and that a restart cancels them and plans them again.

// File: rtl/pdly_trig.sv
module pdly_trig #(
  parameter int CH = 4,
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ext_trig,
  input  logic          dbg_halt,
  output logic [CH-1:0] pretrig,
  output logic          trig
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STRB = AW'(1);
  localparam logic [AW-1:0] A_MOD  = AW'(2);
  localparam logic [AW-1:0] A_CHEN = AW'(3);
  localparam logic [AW-1:0] A_BYP  = AW'(4);
  localparam int DLY_BASE = 8;

  logic          en_q, cont_q, swsel_q, run_q;
  logic [CW-1:0] mod_q, cnt_q;
  logic [CH-1:0] chen_q, byp_q, pre_q, hit;
  logic [CW-1:0] dly_q [CH];
  logic [2:0]    sync_q;

  wire ext_rise = sync_q[1] & ~sync_q[2];
  wire sw_go    = cfg_we && (cfg_addr == A_STRB) && cfg_wdata[0];
  wire start    = en_q & (swsel_q ? sw_go : ext_rise);
  wire adv      = run_q & ~dbg_halt;
  wire at_mod   = (cnt_q == mod_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_trig};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; cont_q <= 1'b0; swsel_q <= 1'b0;
      mod_q <= '0; chen_q <= '0; byp_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: begin
          en_q    <= cfg_wdata[0];
          cont_q  <= cfg_wdata[1];
          swsel_q <= cfg_wdata[2];
        end
        A_MOD:   mod_q  <= cfg_wdata[CW-1:0];
        A_CHEN:  chen_q <= cfg_wdata[CH-1:0];
        A_BYP:   byp_q  <= cfg_wdata[CH-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0; run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0; run_q <= 1'b1;
    end else if (!en_q) begin
      run_q <= 1'b0;
    end else if (adv) begin
      if (!at_mod)     cnt_q <= cnt_q + 1'b1;
      else if (cont_q) cnt_q <= '0;
      else             run_q <= 1'b0;
    end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dly_q[i] <= '0;
      else if (cfg_we && cfg_addr == AW'(DLY_BASE + i)) dly_q[i] <= cfg_wdata[CW-1:0];
    assign hit[i] = adv & en_q & chen_q[i] & ~byp_q[i] & (cnt_q == dly_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     pre_q <= '0;
    else if (start) pre_q <= chen_q & byp_q;
    else            pre_q <= hit;

  assign pretrig = pre_q;
  assign trig    = |pre_q;

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pretrig == '0) && !trig);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run_q && (cnt_q == '0));
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && en_q && at_mod && !cont_q && !start) |=> !run_q);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && en_q && at_mod && cont_q && !start) |=> run_q && (cnt_q == '0));
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pretrig == ($past(chen_q) & $past(byp_q))));
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pretrig) |-> ((pretrig & ~$past(chen_q)) == '0));
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !start) |=> (cnt_q == $past(cnt_q)) && (pretrig == '0));
endmodule

// File: tb/pdly_trig_test.sv
`timescale 1ns/1ps
module pdly_trig_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, ext_trig = 1'b0, dbg_halt = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  pretrig;
  logic        trig;
  int n_chk = 0, n_bad = 0;
  int dlyv [4];

  always #4 clk = ~clk;

  pdly_trig #(.CH(4), .CW(16), .AW(4), .DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_trig(ext_trig), .dbg_halt(dbg_halt),
    .pretrig(pretrig), .trig(trig));

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input logic [3:0] e, input string req, input int t);
    n_chk++;
    if (pretrig !== e || trig !== (|e)) begin
      n_bad++;
      $display("FAIL %s t=%0d: pretrig=%b trig=%b expected pretrig=%b trig=%b",
               req, t, pretrig, trig, e, |e);
    end
  endtask

  task automatic setup(input int m, input bit cont, input bit sw,
                       input logic [3:0] ce, input logic [3:0] bp);
    wr(0, 0);
    wr(2, m); wr(3, ce); wr(4, bp);
    for (int i = 0; i < 4; i++) wr(8 + i, dlyv[i]);
    wr(0, {sw, cont, 1'b1});
  endtask

  function automatic logic [3:0] expv(int t, int base, int m, bit cont,
                                      logic [3:0] ce, logic [3:0] bp);
    logic [3:0] r = '0;
    int k = t - base;
    for (int i = 0; i < 4; i++) begin
      int j = k - 1 - dlyv[i];
      if (!ce[i]) r[i] = 1'b0;
      else if (bp[i]) r[i] = (k == 0);
      else if (dlyv[i] <= m && k >= 1)
        r[i] = cont ? (j >= 0 && (j % (m + 1)) == 0) : (j == 0);
    end
    return r;
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk(4'b0, "R1 reset", 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: disabled, software selected, strobe and ext edge ignored
    for (int i = 0; i < 4; i++) dlyv[i] = i;
    setup(5, 1'b0, 1'b1, 4'hF, 4'h1);
    wr(0, 4);
    wr(1, 1);
    ext_trig = 1'b1;
    for (int t = 1; t <= 10; t++) begin chk(4'b0, "R1 disabled", t); @(negedge clk); end
    ext_trig = 1'b0;
    repeat (4) @(negedge clk);

    // R3: software selected, external edges ignored
    wr(0, 5);
    ext_trig = 1'b1;
    for (int t = 1; t <= 10; t++) begin chk(4'b0, "R3 ext ignored", t); @(negedge clk); end
    ext_trig = 1'b0;
    repeat (4) @(negedge clk);

    // R2: external selected, strobe ignored, then edge timing (R4, R5, R11)
    dlyv[0] = 3; dlyv[1] = 0; dlyv[2] = 3; dlyv[3] = 12;
    setup(9, 1'b0, 1'b0, 4'hF, 4'h1);
    wr(1, 1);
    for (int t = 1; t <= 8; t++) begin chk(4'b0, "R2 strobe ignored", t); @(negedge clk); end
    ext_trig = 1'b1;
    for (int t = 1; t <= 20; t++) begin
      @(negedge clk);
      chk(expv(t, 3, 9, 1'b0, 4'hF, 4'h1), "R2 ext start", t);
    end
    ext_trig = 1'b0;
    for (int t = 1; t <= 6; t++) begin @(negedge clk); chk(4'b0, "R2 falling edge", t); end

    // Sweep: R4 R5 R6 R7 R8
    for (int m = 0; m <= 4; m++)
      for (int c = 0; c <= 1; c++)
        for (int b = 0; b <= 3; b++) begin
          logic [3:0] bp = {b[1], 2'b00, b[0]};
          logic [3:0] ce = (b == 3) ? 4'b1011 : 4'b1111;
          for (int i = 0; i < 4; i++) dlyv[i] = (i * 2 + m) % (m + 3);
          setup(m, c[0], 1'b1, ce, bp);
          wr(1, 1);
          for (int t = 1; t <= 20; t++) begin
            chk(expv(t, 1, m, c[0], ce, bp), c ? "R6 continuous" : "R5 one-shot", t);
            @(negedge clk);
          end
        end

    // R9: halt for 5 edges shifts the delayed pulse by 5
    dlyv[0] = 0; dlyv[1] = 6; dlyv[2] = 0; dlyv[3] = 0;
    setup(20, 1'b0, 1'b1, 4'b0010, 4'b0000);
    wr(1, 1);
    for (int t = 1; t <= 20; t++) begin
      chk((t == 13) ? 4'b0010 : 4'b0000, "R9 halt", t);
      if (t == 2) dbg_halt = 1'b1;
      if (t == 7) dbg_halt = 1'b0;
      @(negedge clk);
    end

    // R10: restart mid-schedule
    dlyv[1] = 5;
    setup(20, 1'b0, 1'b1, 4'b0011, 4'b0001);
    wr(1, 1);
    for (int t = 1; t <= 2; t++) begin
      chk((t == 1) ? 4'b0001 : 4'b0000, "R10 first start", t);
      @(negedge clk);
    end
    chk(4'b0, "R10 first start", 3);
    wr(1, 1);
    for (int t = 1; t <= 15; t++) begin
      chk((t == 1) ? 4'b0001 : (t == 7) ? 4'b0010 : 4'b0000, "R10 restart", t);
      @(negedge clk);
    end

    finish_run();
  end
endmodule